// File: doc/BRIEF.md
# NAND Access Timing Sequencer

This block turns single host transfer requests into timed control sequences on the data port of a NAND flash device. Each request names one of two address spaces, common or attribute. Each space has its own set of three cycle counts: setup, strobe width and hold. The sequencer drives chip enable, the active-low write and read strobes and the output enable of the data bus. It captures read data, and it keeps the host waiting until the hold interval that follows each strobe has run out.

Software normally leaves the common hold count at its minimum so that ordinary data moves stay fast. For one particular write, such as the last address byte before the device goes busy, software uses the attribute space and programs a long attribute hold. The long write-to-busy gap is then paid only on that one write. Reads always finish with a hold taken from the common hold count plus a fixed extra amount.

Top module: `nand_access_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `nand_ce_n`, `nand_we_n` and `nand_re_n` are high, `dq_oe` and `rd_valid` are low, and `ready` is high.
- R2: `ready` is high exactly when no access is in progress. A request seen with `ready` high at a rising edge is accepted at that edge. `ready` is low from the next cycle until the last hold cycle, and it is high again in the cycle after that.
- R3: An access begins with a setup phase of max(setup,1) cycles. In this phase `nand_ce_n` is low and both strobes are high.
- R4: The setup phase is followed by a strobe phase of max(wait,1) cycles. A write (`req_write`=1) drives `nand_we_n` low and a read (`req_write`=0) drives `nand_re_n` low. The two strobes are never low together.
- R5: After `nand_we_n` rises, `nand_ce_n` stays low for exactly max(hold,1) cycles. The hold count is `attr_hold` when `req_attr`=1 and `cmn_hold` when `req_attr`=0.
- R6: After `nand_re_n` rises, `nand_ce_n` stays low for exactly max(`cmn_hold`+RD_HOLD_EXTRA,1) cycles, whatever the space. RD_HOLD_EXTRA defaults to 2.
- R7: The setup and wait counts come from the attribute set (`attr_setup`, `attr_wait`) when `req_attr`=1 and from the common set (`cmn_setup`, `cmn_wait`) when `req_attr`=0.
- R8: For a write, `dq_oe` is high and `dq_o` carries the accepted `req_wdata` from the first setup cycle through the last hold cycle. `dq_oe` is low during reads and while idle.
- R9: `rd_data` takes the value that `dq_i` has at the rising edge where `nand_re_n` goes high. `rd_valid` is high for exactly the one cycle after that edge.
- R10: The space, direction, write data and all counts are taken at acceptance. Changing any of these inputs during an access does not affect that access.
- R11: A request presented while `ready` is low is ignored until `ready` returns high. A request that is still held then is accepted at the next edge, so back-to-back accesses leave one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmn_setup | input | CNT_W | Common space setup count |
| cmn_wait | input | CNT_W | Common space strobe count |
| cmn_hold | input | CNT_W | Common space hold count (also base of read hold) |
| attr_setup | input | CNT_W | Attribute space setup count |
| attr_wait | input | CNT_W | Attribute space strobe count |
| attr_hold | input | CNT_W | Attribute space hold count |
| req_valid | input | 1 | Host request |
| req_attr | input | 1 | 1 = attribute space, 0 = common space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Write data |
| ready | output | 1 | High when a new request can be accepted |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| dq_o | output | DW | Data bus output value |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | DW | Data bus input value |
| rd_data | output | DW | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when rd_data is new |

## Verification
The end of one access's hold phase and the acceptance of the next request can fall on the same boundary. The bench provokes this by holding `req_valid` high through whole busy periods, while the write data and timing inputs change every cycle. A behavioural model expands each accepted request into its expected per-cycle pin pattern. On every clock it judges that `ready` rises for exactly one cycle, that the next setup starts right after it, and that the new access uses only the values present at that acceptance edge. Strobe release and read capture share one edge as well, and the bench judges this by changing `dq_i` every cycle.

// File: rtl/nand_seq_pkg.sv
`timescale 1ns/1ps
package nand_seq_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_HOLD   = 2'd3
   } phase_e;
endpackage

// File: rtl/nand_timing_sel.sv
`timescale 1ns/1ps
// Chooses the three phase lengths of one access from the two timing sets.
module nand_timing_sel #(
   parameter int CNT_W         = 4,
   parameter int RD_HOLD_EXTRA = 2,
   localparam int LEN_W        = CNT_W + 1
) (
   input  logic [CNT_W-1:0] cmn_setup,
   input  logic [CNT_W-1:0] cmn_wait,
   input  logic [CNT_W-1:0] cmn_hold,
   input  logic [CNT_W-1:0] attr_setup,
   input  logic [CNT_W-1:0] attr_wait,
   input  logic [CNT_W-1:0] attr_hold,
   input  logic             use_attr,
   input  logic             is_write,
   output logic [LEN_W-1:0] setup_len,
   output logic [LEN_W-1:0] wait_len,
   output logic [LEN_W-1:0] hold_len
);
   function automatic logic [LEN_W-1:0] at_least_one(input logic [LEN_W-1:0] v);
      return (v == '0) ? LEN_W'(1) : v;
   endfunction

   logic [LEN_W-1:0] rd_hold_raw;
   logic [LEN_W-1:0] wr_hold_raw;

   generate
      if (RD_HOLD_EXTRA == 0) begin : g_rd_plain
         assign rd_hold_raw = LEN_W'(cmn_hold);
      end else begin : g_rd_ext
         assign rd_hold_raw = LEN_W'(cmn_hold) + LEN_W'(RD_HOLD_EXTRA);
      end
   endgenerate

   assign wr_hold_raw = use_attr ? LEN_W'(attr_hold) : LEN_W'(cmn_hold);

   assign setup_len = at_least_one(use_attr ? LEN_W'(attr_setup) : LEN_W'(cmn_setup));
   assign wait_len  = at_least_one(use_attr ? LEN_W'(attr_wait)  : LEN_W'(cmn_wait));
   assign hold_len  = at_least_one(is_write ? wr_hold_raw : rd_hold_raw);
endmodule

// File: rtl/nand_phase_ctr.sv
`timescale 1ns/1ps
// Down-counter measuring the remaining cycles of the current phase.
module nand_phase_ctr #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - W'(1);
      end
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/nand_access_seq.sv
`timescale 1ns/1ps
module nand_access_seq
   import nand_seq_pkg::*;
#(
   parameter int DW            = 8,
   parameter int CNT_W         = 4,
   parameter int RD_HOLD_EXTRA = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cmn_setup,
   input  logic [CNT_W-1:0] cmn_wait,
   input  logic [CNT_W-1:0] cmn_hold,
   input  logic [CNT_W-1:0] attr_setup,
   input  logic [CNT_W-1:0] attr_wait,
   input  logic [CNT_W-1:0] attr_hold,
   input  logic             req_valid,
   input  logic             req_attr,
   input  logic             req_write,
   input  logic [DW-1:0]    req_wdata,
   output logic             ready,
   output logic             nand_ce_n,
   output logic             nand_we_n,
   output logic             nand_re_n,
   output logic [DW-1:0]    dq_o,
   output logic             dq_oe,
   input  logic [DW-1:0]    dq_i,
   output logic [DW-1:0]    rd_data,
   output logic             rd_valid
);
   localparam int LEN_W = CNT_W + 1;

   generate
      if (DW < 1) begin : g_bad_dw
         $error("nand_access_seq: DW must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("nand_access_seq: CNT_W must lie in 1..16");
      end
      if (RD_HOLD_EXTRA < 0 || RD_HOLD_EXTRA > (1 << CNT_W)) begin : g_bad_extra
         $error("nand_access_seq: RD_HOLD_EXTRA out of range");
      end
   endgenerate

   phase_e           phase_q;
   logic             wr_q;
   logic [DW-1:0]    wd_q;
   logic [LEN_W-1:0] wait_q, hold_q;
   logic [LEN_W-1:0] sel_setup, sel_wait, sel_hold;
   logic             accept;
   logic             ctr_load;
   logic [LEN_W-1:0] ctr_val;
   logic             ctr_done;
   logic             strobe_end;

   nand_timing_sel #(
      .CNT_W(CNT_W), .RD_HOLD_EXTRA(RD_HOLD_EXTRA)
   ) u_sel (
      .cmn_setup(cmn_setup), .cmn_wait(cmn_wait), .cmn_hold(cmn_hold),
      .attr_setup(attr_setup), .attr_wait(attr_wait), .attr_hold(attr_hold),
      .use_attr(req_attr), .is_write(req_write),
      .setup_len(sel_setup), .wait_len(sel_wait), .hold_len(sel_hold)
   );

   nand_phase_ctr #(.W(LEN_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .load(ctr_load), .load_val(ctr_val), .done(ctr_done)
   );

   assign accept     = (phase_q == PH_IDLE) && req_valid;
   assign strobe_end = (phase_q == PH_STROBE) && ctr_done;

   always_comb begin
      ctr_load = 1'b0;
      ctr_val  = '0;
      unique case (phase_q)
         PH_IDLE:   begin ctr_load = accept;   ctr_val = sel_setup - LEN_W'(1); end
         PH_SETUP:  begin ctr_load = ctr_done; ctr_val = wait_q - LEN_W'(1);    end
         PH_STROBE: begin ctr_load = ctr_done; ctr_val = hold_q - LEN_W'(1);    end
         default:   begin ctr_load = 1'b0;     ctr_val = '0;                    end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         wr_q     <= 1'b0;
         wd_q     <= '0;
         wait_q   <= LEN_W'(1);
         hold_q   <= LEN_W'(1);
         rd_data  <= '0;
         rd_valid <= 1'b0;
      end else begin
         rd_valid <= strobe_end && !wr_q;
         if (strobe_end && !wr_q) rd_data <= dq_i;
         unique case (phase_q)
            PH_IDLE: if (accept) begin
               phase_q <= PH_SETUP;
               wr_q    <= req_write;
               wd_q    <= req_wdata;
               wait_q  <= sel_wait;
               hold_q  <= sel_hold;
            end
            PH_SETUP:  if (ctr_done) phase_q <= PH_STROBE;
            PH_STROBE: if (ctr_done) phase_q <= PH_HOLD;
            default:   if (ctr_done) phase_q <= PH_IDLE;
         endcase
      end
   end

   assign ready     = (phase_q == PH_IDLE);
   assign nand_ce_n = (phase_q == PH_IDLE);
   assign nand_we_n = !((phase_q == PH_STROBE) && wr_q);
   assign nand_re_n = !((phase_q == PH_STROBE) && !wr_q);
   assign dq_oe     = wr_q && (phase_q != PH_IDLE);
   assign dq_o      = wd_q;
endmodule

// File: rtl/nand_access_seq_chk.sv
`timescale 1ns/1ps
module nand_access_seq_chk #(
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          ready,
   input logic          nand_ce_n,
   input logic          nand_we_n,
   input logic          nand_re_n,
   input logic [DW-1:0] dq_o,
   input logic          dq_oe,
   input logic          rd_valid
);
   assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!nand_we_n && !nand_re_n));

   assert_ce_under_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!nand_we_n || !nand_re_n) |-> !nand_ce_n);

   assert_no_drive_on_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !nand_re_n |-> !dq_oe);

   assert_capture_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (nand_re_n && !$past(nand_re_n)));

   assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> (!ready && !nand_ce_n));

   assert_idle_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (nand_ce_n && nand_we_n && nand_re_n && !dq_oe));

   assert_hold_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nand_we_n) |-> !nand_ce_n);

   assert_data_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> (ready || $stable(dq_o)));
endmodule

bind nand_access_seq nand_access_seq_chk #(.DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ready(ready),
   .nand_ce_n(nand_ce_n), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
   .dq_o(dq_o), .dq_oe(dq_oe), .rd_valid(rd_valid)
);

// File: tb/sim_nand_access_seq.sv
`timescale 1ns/1ps
module sim_nand_access_seq;
   localparam int DW = 8;
   localparam int CW = 4;
   localparam int XTRA = 2;

   typedef struct packed {
      logic          ce_n;
      logic          we_n;
      logic          re_n;
      logic          oe;
      logic          rv;
      logic [DW-1:0] d;
      logic [2:0]    tag;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [CW-1:0] cmn_setup = '0, cmn_wait = '0, cmn_hold = '0;
   logic [CW-1:0] attr_setup = '0, attr_wait = '0, attr_hold = '0;
   logic req_valid = 1'b0, req_attr = 1'b0, req_write = 1'b0;
   logic [DW-1:0] req_wdata = '0;
   logic [DW-1:0] dq_i = '0;
   logic ready, nand_ce_n, nand_we_n, nand_re_n, dq_oe, rd_valid;
   logic [DW-1:0] dq_o, rd_data;

   int tests = 0;
   int fails = 0;
   bit last_idle = 1'b1;
   bit pushed = 1'b0;
   exp_t q[$];

   always #5 clk = ~clk;

   nand_access_seq #(.DW(DW), .CNT_W(CW), .RD_HOLD_EXTRA(XTRA)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmn_setup(cmn_setup), .cmn_wait(cmn_wait), .cmn_hold(cmn_hold),
      .attr_setup(attr_setup), .attr_wait(attr_wait), .attr_hold(attr_hold),
      .req_valid(req_valid), .req_attr(req_attr), .req_write(req_write),
      .req_wdata(req_wdata), .ready(ready), .nand_ce_n(nand_ce_n),
      .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .dq_o(dq_o), .dq_oe(dq_oe),
      .dq_i(dq_i), .rd_data(rd_data), .rd_valid(rd_valid)
   );

   function automatic string tname(input logic [2:0] t);
      case (t)
         3'd3: return "R3 setup";
         3'd4: return "R4 strobe";
         3'd5: return "R5 write-hold";
         3'd6: return "R6 read-hold";
         default: return "R2 idle";
      endcase
   endfunction

   task automatic check(input bit ok, input string what, input int act, input int expv);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: act=%0h exp=%0h", what, act, expv);
      end
   endtask

   // Behavioural expansion of one accepted request into per-cycle pin values.
   task automatic push_access();
      int s, w, h;
      bit wr = req_write;
      s = req_attr ? int'(attr_setup) : int'(cmn_setup);
      w = req_attr ? int'(attr_wait)  : int'(cmn_wait);
      if (wr) h = req_attr ? int'(attr_hold) : int'(cmn_hold);
      else    h = int'(cmn_hold) + XTRA;
      if (s < 1) s = 1;
      if (w < 1) w = 1;
      if (h < 1) h = 1;
      for (int i = 0; i < s; i++)
         q.push_back('{ce_n:1'b0, we_n:1'b1, re_n:1'b1, oe:wr, rv:1'b0, d:req_wdata, tag:3'd3});
      for (int i = 0; i < w; i++)
         q.push_back('{ce_n:1'b0, we_n:!wr, re_n:wr, oe:wr, rv:1'b0, d:req_wdata, tag:3'd4});
      for (int i = 0; i < h; i++)
         q.push_back('{ce_n:1'b0, we_n:1'b1, re_n:1'b1, oe:wr, rv:(i == 0) && !wr,
                       d:req_wdata, tag:(wr ? 3'd5 : 3'd6)});
   endtask

   // One clock: decide acceptance at the coming edge, then compare at the negedge.
   task automatic step();
      exp_t cur;
      logic [DW-1:0] snap;
      bit idle_now;
      pushed = 1'b0;
      if (last_idle && req_valid && rst_n) begin
         push_access();
         pushed = 1'b1;
      end
      dq_i = dq_i + 8'h1d;
      snap = dq_i;
      @(negedge clk);
      if (q.size() > 0) begin
         cur = q.pop_front();
         idle_now = 1'b0;
      end else begin
         cur = '{ce_n:1'b1, we_n:1'b1, re_n:1'b1, oe:1'b0, rv:1'b0, d:'0, tag:3'd2};
         idle_now = 1'b1;
      end
      last_idle = idle_now;
      check(ready === idle_now, "R2 ready", int'(ready), int'(idle_now));
      check(nand_ce_n === cur.ce_n, {tname(cur.tag), " ce_n"}, int'(nand_ce_n), int'(cur.ce_n));
      check(nand_we_n === cur.we_n, {tname(cur.tag), " we_n"}, int'(nand_we_n), int'(cur.we_n));
      check(nand_re_n === cur.re_n, {tname(cur.tag), " re_n"}, int'(nand_re_n), int'(cur.re_n));
      check(dq_oe === cur.oe, "R8 dq_oe", int'(dq_oe), int'(cur.oe));
      if (cur.oe) check(dq_o === cur.d, "R8/R10 dq_o", int'(dq_o), int'(cur.d));
      check(rd_valid === cur.rv, "R9 rd_valid", int'(rd_valid), int'(cur.rv));
      if (cur.rv) check(rd_data === snap, "R9 rd_data", int'(rd_data), int'(snap));
   endtask

   task automatic access(input bit a, input bit w, input logic [DW-1:0] d);
      req_attr = a; req_write = w; req_wdata = d; req_valid = 1'b1;
      do step(); while (!pushed);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      while (q.size() > 0) step();
      step();
   endtask

   task automatic set_cmn(input int s, input int w, input int h);
      cmn_setup = CW'(s); cmn_wait = CW'(w); cmn_hold = CW'(h);
   endtask

   task automatic set_attr(input int s, input int w, input int h);
      attr_setup = CW'(s); attr_wait = CW'(w); attr_hold = CW'(h);
   endtask

   initial begin
      // R1: reset state, during reset and in the first cycle after it
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         check(nand_ce_n && nand_we_n && nand_re_n && !dq_oe && !rd_valid && ready,
               "R1 reset pins", {nand_ce_n, nand_we_n, nand_re_n, dq_oe, rd_valid, ready}, 6'b111001);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check(nand_ce_n && nand_we_n && nand_re_n && !dq_oe && !rd_valid && ready,
            "R1 after reset", {nand_ce_n, nand_we_n, nand_re_n, dq_oe, rd_valid, ready}, 6'b111001);

      // R3 R4 R5: common-space write
      set_cmn(2, 3, 1); set_attr(4, 2, 9);
      access(1'b0, 1'b1, 8'hA5); drain();
      // R6 R9: common-space read, hold = cmn_hold + 2
      access(1'b0, 1'b0, 8'h00); drain();
      // R5 R7: attribute write with long hold, common hold at zero
      set_cmn(0, 0, 0); set_attr(3, 1, 12);
      access(1'b1, 1'b1, 8'h3C); drain();
      // R6 R7: attribute read still uses common hold plus extra
      access(1'b1, 1'b0, 8'h00); drain();
      // R3 R4 R5: all counts zero give one cycle per phase
      set_cmn(0, 0, 0); set_attr(0, 0, 0);
      access(1'b0, 1'b1, 8'h11); drain();
      access(1'b1, 1'b0, 8'h00); drain();

      // R10: timing and data inputs change during an access
      set_cmn(2, 2, 2);
      access(1'b0, 1'b1, 8'h77);
      req_wdata = 8'hEE; req_write = 1'b0; set_cmn(9, 9, 9); set_attr(7, 7, 7);
      drain();

      // R11: request held high across busy periods; inputs churn every cycle
      set_cmn(1, 2, 0); set_attr(2, 1, 5);
      req_valid = 1'b1;
      for (int i = 0; i < 120; i++) begin
         req_attr  = i[2];
         req_write = i[0] ^ i[3];
         req_wdata = 8'(i * 7 + 3);
         step();
      end
      req_valid = 1'b0;
      drain();

      // Mixed traffic with varied timing sets
      for (int k = 0; k < 60; k++) begin
         set_cmn(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)), int'($urandom_range(0, 6)));
         set_attr(int'($urandom_range(0, 6)), int'($urandom_range(0, 6)), int'($urandom_range(0, 15)));
         access(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)));
         if (k % 3 == 0) drain();
         else while (q.size() > 0) step();
      end
      drain();

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #1_900_000;
      fails++;
      $display("FAIL R2 watchdog: act=%0h exp=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule